// File: doc/BRIEF.md
# DSP Core Run-State Controller

This block decides whether a programmable audio processing core runs its program, parks in a hibernated state, or has its clock gated off. The host drives it through three control bits: a hibernate level bit, a stop-core command bit and a start-core bit. The core returns a pulse at the end of every audio frame. From these inputs the controller drives an interrupt mask, a force-NOP signal and a clock-gate enable for the core, and reports where it is in the sequence as a 2-bit state code.

A safe shutdown happens in three steps. The host sets hibernate, which masks interrupts so that no new frame begins. The controller then waits for the frame in progress to finish, or for a whole block of frames when block processing is on. Only after that does a stop-core write gate the clock. Restart is the same sequence in reverse: a rising edge on the start-core bit brings the clock back, and clearing hibernate resumes the program. A stop-core write that arrives too early is dropped and leaves a sticky error flag. The start-core bit can never stop the core.

Top module: `core_runstate_ctrl`

## Requirements
- R1: `irq_mask` is high in every state except running. `force_nop` is high in hibernated-idle and stopped. `core_clk_en` is low only in stopped.
- R2: A hibernate write of 1 (`hib_wr`=1, `hib_val`=1) while running moves the state to draining on the next cycle. Draining holds until enough `frame_done` pulses arrive or hibernate is cleared.
- R3: The drain length is 1 frame when `blk_en` is 0 and `blk_len` frames when `blk_en` is 1, with `blk_len`=0 treated as 1. The state moves to hibernated-idle in the cycle after the pulse that uses up the count.
- R4: A stop write (`stop_wr`=1, `stop_val`=1) in hibernated-idle moves the state to stopped on the next cycle. Outside reset, no other path leads into stopped.
- R5: A start rising edge is a start write of 1 when the last value written to the start bit was 0. In stopped, such an edge moves the state to hibernated-idle if the hibernate bit is 1 after that cycle's write, and to running if it is 0. Without an edge, stopped holds.
- R6: A start write in running, draining or hibernated-idle has no effect on the state.
- R7: A stop write in running or draining is ignored and sets `seq_err`, which stays high until reset. A stop write in stopped does nothing.
- R8: A hibernate write of 0 in draining or hibernated-idle returns the state to running on the next cycle. In hibernated-idle, a stop write in the same cycle takes priority over the hibernate write.
- R9: `run_state` encodes 2'b00 running, 2'b01 draining, 2'b10 hibernated-idle and 2'b11 stopped.
- R10: After reset the state is stopped, the hibernate bit is 1, the stored start bit is 0 and `seq_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hib_wr | input | 1 | Write strobe for the hibernate bit |
| hib_val | input | 1 | Hibernate bit value to write |
| stop_wr | input | 1 | Write strobe for the stop-core bit |
| stop_val | input | 1 | Stop-core value; 1 requests a stop |
| start_wr | input | 1 | Write strobe for the start-core bit |
| start_val | input | 1 | Start-core value; a 0-to-1 change is a start |
| frame_done | input | 1 | One-cycle pulse at the end of each frame |
| blk_en | input | 1 | Block processing enable |
| blk_len | input | LEN_W | Frames per block |
| irq_mask | output | 1 | Masks all core interrupts |
| force_nop | output | 1 | Core issues only no-operation instructions |
| core_clk_en | output | 1 | Enable for the core clock gate |
| run_state | output | 2 | Encoded controller state |
| seq_err | output | 1 | Sticky flag for a stop write that came too early |

## Verification
The assertions check on every cycle the rules that involve one or two adjacent cycles:
- stopped is entered only from hibernated-idle;
- running ignores everything except a hibernate request;
- draining holds while no frame ends;
- clearing hibernate aborts a drain;
- a premature stop write raises the error flag, and the flag never clears;
- the gate, mask and NOP outputs stay mutually consistent.

Only the bench's scenarios can show the exact drain length for each block setting, including a length of zero. The same holds for start edge detection across repeated writes of 1, and for the choice between idle and running on restart, which depends on the hibernate bit. A seeded random sequence compared against a bench model covers interleavings of writes and frame pulses that the directed cases miss.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

    typedef enum logic [1:0] {
        RC_RUN   = 2'b00,
        RC_DRAIN = 2'b01,
        RC_HIBER = 2'b10,
        RC_HALT  = 2'b11
    } rc_state_e;

    typedef struct packed {
        rc_state_e st;
        logic      hib;
        logic      err;
    } rc_ctl_t;

endpackage

// File: rtl/rcc_start_edge.sv
module rcc_start_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic val,
    output logic rise
);
    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = wr ? val : lvl_q;
        rise  = wr & val & ~lvl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end
endmodule

// File: rtl/rcc_drain_cnt.sv
module rcc_drain_cnt #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic             blk_en,
    input  logic [LEN_W-1:0] blk_len,
    output logic             last
);
    localparam logic [LEN_W-1:0] ONE  = LEN_W'(1);
    localparam logic [LEN_W-1:0] ZERO = '0;

    logic [LEN_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = (blk_en && blk_len != ZERO) ? blk_len : ONE;
        end else if (dec && cnt_q != ZERO) begin
            cnt_d = cnt_q - ONE;
        end
        last = (cnt_q == ONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= ZERO;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rcc_out_map.sv
module rcc_out_map
    import rcc_pkg::*;
(
    input  rc_state_e st,
    output logic      irq_mask,
    output logic      force_nop,
    output logic      core_clk_en
);
    always_comb begin
        irq_mask    = (st != RC_RUN);
        force_nop   = (st == RC_HIBER) || (st == RC_HALT);
        core_clk_en = (st != RC_HALT);
    end
endmodule

// File: rtl/core_runstate_ctrl.sv
module core_runstate_ctrl
    import rcc_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hib_wr,
    input  logic             hib_val,
    input  logic             stop_wr,
    input  logic             stop_val,
    input  logic             start_wr,
    input  logic             start_val,
    input  logic             frame_done,
    input  logic             blk_en,
    input  logic [LEN_W-1:0] blk_len,
    output logic             irq_mask,
    output logic             force_nop,
    output logic             core_clk_en,
    output logic [1:0]       run_state,
    output logic             seq_err
);
    rc_ctl_t ctl_d, ctl_q;
    logic    start_rise;
    logic    cnt_load, cnt_dec, cnt_last;
    logic    hib_set, hib_clr, stop_cmd;

    rcc_start_edge u_start (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (start_wr),
        .val  (start_val),
        .rise (start_rise)
    );

    rcc_drain_cnt #(.LEN_W(LEN_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cnt_load),
        .dec    (cnt_dec),
        .blk_en (blk_en),
        .blk_len(blk_len),
        .last   (cnt_last)
    );

    always_comb begin
        hib_set  = hib_wr & hib_val;
        hib_clr  = hib_wr & ~hib_val;
        stop_cmd = stop_wr & stop_val;
        ctl_d    = ctl_q;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        if (hib_wr) ctl_d.hib = hib_val;
        unique case (ctl_q.st)
            RC_RUN: begin
                if (stop_cmd) ctl_d.err = 1'b1;
                if (hib_set) begin
                    ctl_d.st = RC_DRAIN;
                    cnt_load = 1'b1;
                end
            end
            RC_DRAIN: begin
                if (stop_cmd) ctl_d.err = 1'b1;
                if (hib_clr) begin
                    ctl_d.st = RC_RUN;
                end else if (frame_done) begin
                    cnt_dec = 1'b1;
                    if (cnt_last) ctl_d.st = RC_HIBER;
                end
            end
            RC_HIBER: begin
                if (stop_cmd)     ctl_d.st = RC_HALT;
                else if (hib_clr) ctl_d.st = RC_RUN;
            end
            RC_HALT: begin
                if (start_rise) ctl_d.st = ctl_d.hib ? RC_HIBER : RC_RUN;
            end
            default: ctl_d.st = RC_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st  <= RC_HALT;
            ctl_q.hib <= 1'b1;
            ctl_q.err <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    rcc_out_map u_map (
        .st         (ctl_q.st),
        .irq_mask   (irq_mask),
        .force_nop  (force_nop),
        .core_clk_en(core_clk_en)
    );

    assign run_state = ctl_q.st;
    assign seq_err   = ctl_q.err;
endmodule

// File: rtl/core_runstate_ctrl_chk.sv
module core_runstate_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hib_wr,
    input logic       hib_val,
    input logic       stop_wr,
    input logic       stop_val,
    input logic       start_wr,
    input logic       start_val,
    input logic       frame_done,
    input logic       irq_mask,
    input logic       force_nop,
    input logic       core_clk_en,
    input logic [1:0] run_state,
    input logic       seq_err
);
    AST_GATE_IMPLIES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !core_clk_en |-> (irq_mask && force_nop)); // R1
    AST_NOP_IMPLIES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        force_nop |-> irq_mask); // R1
    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == 2'b01 && !frame_done && !(hib_wr && !hib_val)) |=> run_state == 2'b01); // R2
    AST_HALT_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state != 2'b11 && run_state != 2'b10) |=> run_state != 2'b11); // R4
    AST_IDLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == 2'b10 && stop_wr && stop_val) |=> run_state == 2'b11); // R4
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == 2'b11 && !(start_wr && start_val)) |=> run_state == 2'b11); // R5
    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == 2'b00 && !(hib_wr && hib_val)) |=> run_state == 2'b00); // R6
    AST_EARLY_STOP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ((run_state == 2'b00 || run_state == 2'b01) && stop_wr && stop_val) |=> seq_err); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> seq_err); // R7
    AST_HIB_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        ((run_state == 2'b01 || run_state == 2'b10) && hib_wr && !hib_val && !(stop_wr && stop_val))
        |=> run_state == 2'b00); // R8
endmodule

bind core_runstate_ctrl core_runstate_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hib_wr     (hib_wr),
    .hib_val    (hib_val),
    .stop_wr    (stop_wr),
    .stop_val   (stop_val),
    .start_wr   (start_wr),
    .start_val  (start_val),
    .frame_done (frame_done),
    .irq_mask   (irq_mask),
    .force_nop  (force_nop),
    .core_clk_en(core_clk_en),
    .run_state  (run_state),
    .seq_err    (seq_err)
);

// File: tb/core_runstate_ctrl_test.sv
`timescale 1ns/1ps
module core_runstate_ctrl_test;
    localparam int LEN_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hib_wr = 0, hib_val = 0, stop_wr = 0, stop_val = 0;
    logic start_wr = 0, start_val = 0, frame_done = 0, blk_en = 0;
    logic [LEN_W-1:0] blk_len = '0;
    logic irq_mask, force_nop, core_clk_en, seq_err;
    logic [1:0] run_state;

    int checks = 0;
    int failures = 0;

    // bench model
    logic [1:0] m_st;
    logic m_hib, m_start, m_err;
    int m_cnt;

    always #5 clk = ~clk;

    core_runstate_ctrl #(.LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .hib_wr(hib_wr), .hib_val(hib_val),
        .stop_wr(stop_wr), .stop_val(stop_val),
        .start_wr(start_wr), .start_val(start_val),
        .frame_done(frame_done), .blk_en(blk_en), .blk_len(blk_len),
        .irq_mask(irq_mask), .force_nop(force_nop), .core_clk_en(core_clk_en),
        .run_state(run_state), .seq_err(seq_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int drain_len(input logic en, input logic [LEN_W-1:0] len);
        return (en && len != 0) ? int'(len) : 1;
    endfunction

    task automatic model_reset();
        m_st = 2'b11; m_hib = 1'b1; m_start = 1'b0; m_err = 1'b0; m_cnt = 0;
    endtask

    task automatic model_step();
        logic edge_s, stop_c, hset, hclr;
        edge_s = start_wr && start_val && !m_start;
        stop_c = stop_wr && stop_val;
        hset = hib_wr && hib_val;
        hclr = hib_wr && !hib_val;
        if (hib_wr) m_hib = hib_val;
        if (start_wr) m_start = start_val;
        case (m_st)
            2'b00: begin
                if (stop_c) m_err = 1'b1;
                if (hset) begin m_st = 2'b01; m_cnt = drain_len(blk_en, blk_len); end
            end
            2'b01: begin
                if (stop_c) m_err = 1'b1;
                if (hclr) m_st = 2'b00;
                else if (frame_done) begin
                    if (m_cnt == 1) m_st = 2'b10;
                    if (m_cnt > 0) m_cnt--;
                end
            end
            2'b10: begin
                if (stop_c) m_st = 2'b11;
                else if (hclr) m_st = 2'b00;
            end
            default: if (edge_s) m_st = m_hib ? 2'b10 : 2'b00;
        endcase
    endtask

    task automatic cmp_all();
        chk("R9 state", int'(run_state), int'(m_st));
        chk("R1 irq_mask", int'(irq_mask), int'(m_st != 2'b00));
        chk("R1 force_nop", int'(force_nop), int'(m_st[1]));
        chk("R1 core_clk_en", int'(core_clk_en), int'(m_st != 2'b11));
        chk("R7 seq_err", int'(seq_err), int'(m_err));
    endtask

    // inputs are set at a falling edge; one clock, then compare at the next falling edge
    task automatic cyc(input logic hw, input logic hv, input logic sw, input logic sv,
                       input logic tw, input logic tv, input logic fd);
        hib_wr = hw; hib_val = hv; stop_wr = sw; stop_val = sv;
        start_wr = tw; start_val = tv; frame_done = fd;
        @(posedge clk);
        model_step();
        @(negedge clk);
        hib_wr = 0; stop_wr = 0; start_wr = 0; frame_done = 0;
        cmp_all();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h1A2B3C4D));
        do_reset();
        // R10 reset state
        chk("R10 state", int'(run_state), 3);
        chk("R10 seq_err", int'(seq_err), 0);
        chk("R10 clk_en", int'(core_clk_en), 0);
        chk("R10 irq_mask", int'(irq_mask), 1);

        // R5 start edge with hibernate set -> idle
        cyc(0,0, 0,0, 1,1, 0);
        chk("R5 start to idle", int'(run_state), 2);
        // R8 clearing hibernate resumes
        cyc(1,0, 0,0, 0,0, 0);
        chk("R8 resume", int'(run_state), 0);
        // R6 start edge while running does nothing
        cyc(0,0, 0,0, 1,0, 0);
        cyc(0,0, 0,0, 1,1, 0);
        chk("R6 start in run", int'(run_state), 0);
        // R7 early stop
        cyc(0,0, 1,1, 0,0, 0);
        chk("R7 early stop state", int'(run_state), 0);
        chk("R7 early stop err", int'(seq_err), 1);
        // R2 R3 block drain of 3 frames
        blk_en = 1; blk_len = 3;
        cyc(1,1, 0,0, 0,0, 0);
        chk("R2 draining", int'(run_state), 1);
        cyc(0,0, 0,0, 0,0, 1);
        cyc(0,0, 0,0, 0,0, 1);
        chk("R3 still draining", int'(run_state), 1);
        cyc(0,0, 1,1, 0,0, 0);
        chk("R7 stop in drain ignored", int'(run_state), 1);
        cyc(0,0, 0,0, 0,0, 1);
        chk("R3 drained", int'(run_state), 2);
        // R4 stop from idle, clock gated
        cyc(0,0, 1,1, 0,0, 0);
        chk("R4 stopped", int'(run_state), 3);
        chk("R1 gated", int'(core_clk_en), 0);
        // R5 repeated start 1 without 0 is no edge
        cyc(0,0, 0,0, 1,1, 0);
        chk("R5 no edge", int'(run_state), 3);
        // R10 reset clears error; R5 restart straight to run when hibernate cleared
        do_reset();
        chk("R10 err cleared", int'(seq_err), 0);
        cyc(1,0, 0,0, 0,0, 0);
        chk("R5 stays stopped", int'(run_state), 3);
        cyc(0,0, 0,0, 1,1, 0);
        chk("R5 start to run", int'(run_state), 0);
        // R3 zero block length counts as one frame
        blk_len = 0;
        cyc(1,1, 0,0, 0,0, 0);
        cyc(0,0, 0,0, 0,0, 1);
        chk("R3 zero length", int'(run_state), 2);
        // R8 stop wins over hibernate clear in idle
        cyc(1,0, 1,1, 0,0, 0);
        chk("R8 stop priority", int'(run_state), 3);
        cyc(0,0, 0,0, 1,0, 0);
        cyc(0,0, 0,0, 1,1, 0);
        // R8 abort drain
        blk_en = 1; blk_len = 4;
        cyc(1,0, 0,0, 0,0, 0);
        cyc(1,1, 0,0, 0,0, 0);
        cyc(0,0, 0,0, 0,0, 1);
        cyc(1,0, 0,0, 0,0, 1);
        chk("R8 abort drain", int'(run_state), 0);

        // seeded random phase against the model
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 50) == 0) blk_en = $urandom % 2;
            if (($urandom % 20) == 0) blk_len = LEN_W'($urandom % 5);
            cyc(($urandom % 8) == 0, $urandom % 2,
                ($urandom % 10) == 0, ($urandom % 4) != 0,
                ($urandom % 6) == 0, $urandom % 2,
                ($urandom % 3) == 0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule